// File: doc/BRIEF.md
# Edge-Cleared Capture/Compare Timer

This block is an up-counter with two registers, each of which works as a compare register or a capture register. In the active mode, a selected edge on the primary external input restarts the count from zero. The same edge can also latch the running count into register 1, so the block measures the time between successive primary edges. Register 0 latches the count on an edge of the secondary input, or on the opposite edge of the primary input. In that role it measures the width of a pulse inside each period.

Both external inputs are synchronized and edge-detected inside the block. A count-clock enable from an outside prescaler advances the counter. In compare use, each register raises its own interrupt pulse when the counter steps onto its value. A one-cycle overflow pulse marks every wrap of the counter.

Top module: `edge_clr_timer`

## Requirements
- R1: The block runs only while `mode_i` is 2'b10. For any other value the counter is held at zero, and no interrupt, capture or overflow occurs. Register writes still apply.
- R2: After reset the counter is zero and every output is low or zero. In the active mode the counter goes up by one on each cycle in which `tick_i` is high.
- R3: A valid primary edge sets the counter to zero. This clear takes priority over a tick in the same cycle, and later ticks count up again from zero.
- R4: A tick taken while the counter holds its maximum value (all ones) wraps it to zero. `ovf_o` is then high for exactly the next cycle.
- R5: If bit k of `cap_sel_i` is 0 (compare use), a tick that moves the counter onto the value of register k raises `irq<k>_o` for one cycle. A counter that sits at zero after a clear gives no match.
- R6: If bit 1 of `cap_sel_i` is 1 (capture use), a valid primary edge stores the count held just before the clear into register 1 and raises `irq1_o` for one cycle.
- R7: If bit 0 of `cap_sel_i` is 1, register 0 takes the current count and `irq0_o` pulses on a capture event. With `cap0_src_i`=0 the event is a valid secondary edge. With `cap0_src_i`=1 it is the opposite primary edge.
- R8: Each polarity select uses the encoding 00 none, 01 rising, 10 falling, 11 both. The opposite edge of rising is falling and the opposite of falling is rising. Settings 00 and 11 have no opposite edge.
- R9: Each external input passes through two synchronizer flops and one history flop. A level change applied before clock edge k acts on the state at edge k+2. Its outputs are visible after that edge.
- R10: While `tick_from_edge_i` is high, the counter is held at zero and gives neither compare matches nor overflow. Captures still store the current count.
- R11: A write (`wr_en_i`, `wr_sel_i` choosing register 1 when high) shows on the readback after the next edge. A capture into the same register in the same cycle wins over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Timer mode; 2'b10 = clear on primary edge |
| tick_i | input | 1 | Count-clock enable |
| tick_from_edge_i | input | 1 | Count source wrongly set to the primary edge; holds counter at zero |
| pri_i | input | 1 | Primary external input (asynchronous) |
| sec_i | input | 1 | Secondary external input (asynchronous) |
| pri_pol_i | input | 2 | Primary valid-edge select |
| sec_pol_i | input | 2 | Secondary valid-edge select |
| cap_sel_i | input | 2 | Per register: 0 compare, 1 capture |
| cap0_src_i | input | 1 | Register 0 capture source: 0 secondary, 1 opposite primary edge |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 register 0, 1 register 1 |
| wr_data_i | input | CNT_W | Write data |
| irq0_o | output | 1 | Register 0 match/capture pulse |
| irq1_o | output | 1 | Register 1 match/capture pulse |
| ovf_o | output | 1 | Counter wrap pulse |
| reg0_o | output | CNT_W | Register 0 readback |
| reg1_o | output | CNT_W | Register 1 readback |

## Verification
The bench builds the block with CNT_W=8 and SYNC_STAGES=2. The 8-bit counter wraps every 256 ticks, so a short run reaches overflow pulses and wrap-to-zero compare matches many times. Random register values also hit compare matches often. The two-stage synchronizer fixes the edge-to-effect latency at the value stated in R9. The bench's cycle model relies on that latency to predict the exact cycle of every capture and clear.

// File: rtl/ect_pkg.sv
package ect_pkg;
    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_pol_e;

    localparam logic [1:0] MODE_CLR_START = 2'b10;

    // Valid edge for a polarity setting
    function automatic logic pick_edge(input logic [1:0] pol, input logic rise, input logic fall);
        case (edge_pol_e'(pol))
            EDGE_RISE: pick_edge = rise;
            EDGE_FALL: pick_edge = fall;
            EDGE_BOTH: pick_edge = rise | fall;
            default:   pick_edge = 1'b0;
        endcase
    endfunction

    // Opposite-phase edge; none for "none" and "both"
    function automatic logic pick_opp(input logic [1:0] pol, input logic rise, input logic fall);
        case (edge_pol_e'(pol))
            EDGE_RISE: pick_opp = fall;
            EDGE_FALL: pick_opp = rise;
            default:   pick_opp = 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/ect_sync.sv
module ect_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ect_edge_det.sv
module ect_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
    assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/edge_clr_timer.sv
module edge_clr_timer #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic             tick_i,
    input  logic             tick_from_edge_i,
    input  logic             pri_i,
    input  logic             sec_i,
    input  logic [1:0]       pri_pol_i,
    input  logic [1:0]       sec_pol_i,
    input  logic [1:0]       cap_sel_i,
    input  logic             cap0_src_i,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic             irq0_o,
    output logic             irq1_o,
    output logic             ovf_o,
    output logic [CNT_W-1:0] reg0_o,
    output logic [CNT_W-1:0] reg1_o
);
    import ect_pkg::*;

    localparam int               N_IN    = 2;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] reg0;
        logic [CNT_W-1:0] reg1;
        logic             irq0;
        logic             irq1;
        logic             ovf;
    } state_t;

    state_t st_d, st_q;

    // index 0: primary, index 1: secondary
    logic [N_IN-1:0] raw_lvl, sync_lvl, rise_ev, fall_ev;
    assign raw_lvl = {sec_i, pri_i};

    for (genvar i = 0; i < N_IN; i++) begin : g_in
        ect_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d_i  (raw_lvl[i]),
            .q_o  (sync_lvl[i])
        );
        ect_edge_det u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .lvl_i (sync_lvl[i]),
            .rise_o(rise_ev[i]),
            .fall_o(fall_ev[i])
        );
    end

    logic             run, pri_hit, pri_opp, sec_hit, cap0_ev, cap1_ev;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        run     = (mode_i == MODE_CLR_START);
        pri_hit = pick_edge(pri_pol_i, rise_ev[0], fall_ev[0]);
        pri_opp = pick_opp(pri_pol_i, rise_ev[0], fall_ev[0]);
        sec_hit = pick_edge(sec_pol_i, rise_ev[1], fall_ev[1]);
        cap0_ev = run && cap_sel_i[0] && (cap0_src_i ? pri_opp : sec_hit);
        cap1_ev = run && cap_sel_i[1] && pri_hit;
        cnt_inc = st_q.cnt + 1'b1;

        st_d      = st_q;
        st_d.irq0 = 1'b0;
        st_d.irq1 = 1'b0;
        st_d.ovf  = 1'b0;

        // software write, overridden below by a same-cycle capture
        if (wr_en_i) begin
            if (wr_sel_i) st_d.reg1 = wr_data_i;
            else          st_d.reg0 = wr_data_i;
        end

        // counter: inactive / held, then edge clear, then tick
        if (!run || tick_from_edge_i || pri_hit) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            st_d.cnt = cnt_inc;
            st_d.ovf = (st_q.cnt == CNT_MAX);
            if (!cap_sel_i[0] && (cnt_inc == st_q.reg0)) st_d.irq0 = 1'b1;
            if (!cap_sel_i[1] && (cnt_inc == st_q.reg1)) st_d.irq1 = 1'b1;
        end

        // capture of the count held before any clear
        if (cap0_ev) begin
            st_d.reg0 = st_q.cnt;
            st_d.irq0 = 1'b1;
        end
        if (cap1_ev) begin
            st_d.reg1 = st_q.cnt;
            st_d.irq1 = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq0_o = st_q.irq0;
    assign irq1_o = st_q.irq1;
    assign ovf_o  = st_q.ovf;
    assign reg0_o = st_q.reg0;
    assign reg1_o = st_q.reg1;
endmodule

// File: rtl/ect_checker.sv
module ect_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode_i,
    input logic             tick_from_edge_i,
    input logic [1:0]       cap_sel_i,
    input logic             wr_en_i,
    input logic             wr_sel_i,
    input logic [CNT_W-1:0] wr_data_i,
    input logic             irq0_o,
    input logic             irq1_o,
    input logic             ovf_o,
    input logic [CNT_W-1:0] reg0_o,
    input logic [CNT_W-1:0] reg1_o
);
    // R1: outside the active mode nothing fires
    p_idle_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != 2'b10) |=> (!irq0_o && !irq1_o && !ovf_o));

    // R4: a wrap pulse lasts one cycle
    p_ovf_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> !ovf_o);

    // R10: held counter never overflows
    p_hold_no_ovf_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tick_from_edge_i |=> !ovf_o);

    // R11: write to a compare register lands on the next edge
    p_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_sel_i && !cap_sel_i[0]) |=> (reg0_o == $past(wr_data_i)));

    // R6: register 1 in compare use changes only by a write
    p_reg1_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_sel_i[1] && !(wr_en_i && wr_sel_i)) |=> $stable(reg1_o));
endmodule

bind edge_clr_timer ect_checker #(.CNT_W(CNT_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .mode_i          (mode_i),
    .tick_from_edge_i(tick_from_edge_i),
    .cap_sel_i       (cap_sel_i),
    .wr_en_i         (wr_en_i),
    .wr_sel_i        (wr_sel_i),
    .wr_data_i       (wr_data_i),
    .irq0_o          (irq0_o),
    .irq1_o          (irq1_o),
    .ovf_o           (ovf_o),
    .reg0_o          (reg0_o),
    .reg1_o          (reg1_o)
);

// File: tb/edge_clr_timer_bench.sv
module edge_clr_timer_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   mode_i = 2'b00;
    logic         tick_i = 1'b0, tick_from_edge_i = 1'b0;
    logic         pri_i = 1'b0, sec_i = 1'b0;
    logic [1:0]   pri_pol_i = 2'b01, sec_pol_i = 2'b01, cap_sel_i = 2'b00;
    logic         cap0_src_i = 1'b0, wr_en_i = 1'b0, wr_sel_i = 1'b0;
    logic [W-1:0] wr_data_i = '0;
    logic         irq0_o, irq1_o, ovf_o;
    logic [W-1:0] reg0_o, reg1_o;

    always #10 clk = ~clk;

    edge_clr_timer #(.CNT_W(W), .SYNC_STAGES(2)) u_edge_clr_timer (.*);

    int n_vec = 0, n_bad = 0;
    bit done = 0;

    // bench model state
    logic [W-1:0] m_cnt, m_r0, m_r1;
    logic         m_i0, m_i1, m_ov;
    logic         p1, p2, pp, s1, s2, sp;

    function automatic logic edge_of(logic [1:0] pol, logic r, logic f);
        return (pol == 2'b01) ? r : (pol == 2'b10) ? f : (pol == 2'b11) ? (r | f) : 1'b0;
    endfunction
    function automatic logic opp_of(logic [1:0] pol, logic r, logic f);
        return (pol == 2'b01) ? f : (pol == 2'b10) ? r : 1'b0;
    endfunction

    task automatic model_reset();
        m_cnt = '0; m_r0 = '0; m_r1 = '0; m_i0 = 0; m_i1 = 0; m_ov = 0;
        p1 = 0; p2 = 0; pp = 0; s1 = 0; s2 = 0; sp = 0;
    endtask

    // one clock of the requirement-level model, using the inputs now driven
    task automatic model_step();
        logic run, ph, po, sh, c0, c1;
        logic [W-1:0] nc, n0, n1, inc;
        logic ni0, ni1, nov;
        if (!rst_n) begin model_reset(); return; end
        run = (mode_i == 2'b10);                                   // R1
        ph  = edge_of(pri_pol_i, p2 & ~pp, ~p2 & pp);              // R8 R9
        po  = opp_of(pri_pol_i, p2 & ~pp, ~p2 & pp);
        sh  = edge_of(sec_pol_i, s2 & ~sp, ~s2 & sp);
        c0  = run && cap_sel_i[0] && (cap0_src_i ? po : sh);       // R7
        c1  = run && cap_sel_i[1] && ph;                           // R6
        nc = m_cnt; n0 = m_r0; n1 = m_r1; ni0 = 0; ni1 = 0; nov = 0;
        inc = m_cnt + 1'b1;
        if (wr_en_i) begin if (wr_sel_i) n1 = wr_data_i; else n0 = wr_data_i; end  // R11
        if (!run || tick_from_edge_i || ph) nc = '0;               // R3 R10
        else if (tick_i) begin                                     // R2
            nc = inc; nov = (m_cnt == {W{1'b1}});                  // R4
            if (!cap_sel_i[0] && inc == m_r0) ni0 = 1;             // R5
            if (!cap_sel_i[1] && inc == m_r1) ni1 = 1;
        end
        if (c0) begin n0 = m_cnt; ni0 = 1; end
        if (c1) begin n1 = m_cnt; ni1 = 1; end
        m_cnt = nc; m_r0 = n0; m_r1 = n1; m_i0 = ni0; m_i1 = ni1; m_ov = nov;
        pp = p2; p2 = p1; p1 = pri_i; sp = s2; s2 = s1; s1 = sec_i;
    endtask

    task automatic chk(string tag, string what, logic [W-1:0] got, logic [W-1:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic check_all(string tag);
        chk(tag, "irq0", W'(irq0_o), W'(m_i0));
        chk(tag, "irq1", W'(irq1_o), W'(m_i1));
        chk(tag, "ovf",  W'(ovf_o),  W'(m_ov));
        chk(tag, "reg0", reg0_o, m_r0);
        chk(tag, "reg1", reg1_o, m_r1);
    endtask

    // called at a negative edge with inputs driven
    task automatic step(string tag);
        model_step();
        @(negedge clk);
        if (rst_n) check_all(tag);
    endtask

    task automatic rand_run(string tag, int n, int p_edge);
        for (int i = 0; i < n; i++) begin
            tick_i  = ($urandom % 4) != 0;
            if ($urandom % p_edge == 0) pri_i = ~pri_i;
            if ($urandom % p_edge == 0) sec_i = ~sec_i;
            wr_en_i   = ($urandom % 16) == 0;
            wr_sel_i  = $urandom % 2;
            wr_data_i = W'($urandom);
            step(tag);
        end
        wr_en_i = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R2: reset state
        check_all("R2");

        // R1: inactive mode, random traffic including captures configured
        mode_i = 2'b00; cap_sel_i = 2'b11;
        rand_run("R1", 200, 6);
        mode_i = 2'b11;
        rand_run("R1", 100, 6);

        // R2 R3 R6 R9: count then a single rising primary edge
        pri_i = 0; sec_i = 0;
        repeat (4) step("R9");
        mode_i = 2'b10; cap_sel_i = 2'b10; pri_pol_i = 2'b01; tick_i = 1;
        repeat (20) step("R2");
        pri_i = 1;
        step("R9"); step("R9");
        chk("R9", "irq1 early", W'(irq1_o), 0);
        step("R6");
        chk("R6", "irq1 on capture", W'(irq1_o), 1);
        chk("R6", "reg1 captured", reg1_o, W'(22));
        // R3: resumes from zero, tick was high during the clear
        repeat (5) step("R3");
        pri_i = 0;
        repeat (3) step("R3");

        // R4 R5: free running wraps with compare registers
        cap_sel_i = 2'b00; wr_en_i = 1; wr_sel_i = 0; wr_data_i = 8'h00; step("R11");
        wr_sel_i = 1; wr_data_i = 8'h80; step("R11");
        wr_en_i = 0; tick_i = 1;
        repeat (700) step("R4 R5");

        // R10: count source set to the primary edge
        tick_from_edge_i = 1; cap_sel_i = 2'b11;
        rand_run("R10", 400, 5);
        tick_from_edge_i = 0;

        // R7 R8: every polarity pair and both register-0 sources
        for (int pp_i = 0; pp_i < 4; pp_i++)
            for (int sp_i = 0; sp_i < 4; sp_i++)
                for (int src = 0; src < 2; src++) begin
                    pri_pol_i = pp_i[1:0]; sec_pol_i = sp_i[1:0];
                    cap0_src_i = src[0]; cap_sel_i = 2'b01;
                    rand_run("R7 R8", 120, 7);
                end

        // R11: write and capture into register 1 in the same cycle
        pri_pol_i = 2'b11; cap_sel_i = 2'b10; tick_i = 1;
        pri_i = ~pri_i;
        step("R11"); step("R11");
        wr_en_i = 1; wr_sel_i = 1; wr_data_i = 8'hA5;
        step("R11");
        wr_en_i = 0;
        chk("R11", "capture wins", W'(reg1_o == 8'hA5), 0);
        repeat (4) step("R11");

        // mixed random traffic
        for (int blk = 0; blk < 60; blk++) begin
            cap_sel_i = 2'($urandom); cap0_src_i = $urandom % 2;
            pri_pol_i = 2'($urandom); sec_pol_i = 2'($urandom);
            rand_run("R5 R6 R7", 300, 40);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule